// File: doc/BRIEF.md
# Serial Flag-Offset Loader

This block keeps the programmable almost-empty and almost-full thresholds for four queues. Each queue has two thresholds, so the block holds eight offset fields, and all of them are written as one serial bit stream on a single data pin. The fields are of equal width, set by the `FIELD_W` parameter. The intended widths run from 13 to 17 bits, so a complete stream is 104 to 136 bits long. The stored thresholds are driven in parallel to the flag logic of each queue.

Changing a threshold means reloading all eight fields in one uninterrupted stream. The new values become visible only after the last bit of that stream has arrived. A stream that stops early is discarded, and the thresholds already in use stay untouched.

A read-back command shifts the stored image out on a serial output. The bits come out in the same order that a load puts them in. A one-cycle `done` pulse marks the end of every completed load and every completed read-back.

The controller has three states:
- `ST_IDLE` waits for work.
- `ST_LOAD` collects stream bits.
- `ST_READ` shifts the stored image out.

The state transitions are:

| Transition | Condition | Effect |
|---|---|---|
| `ST_IDLE` → `ST_LOAD` | `load_en` is high | The first bit is taken. |
| `ST_IDLE` → `ST_READ` | A valid read command arrives and `load_en` is low | Read-back starts. |
| `ST_LOAD` → `ST_LOAD` | Each further enabled bit before the last | Collection continues. |
| `ST_LOAD` → `ST_IDLE` | The final bit is taken | The new values are committed and `done` is raised. |
| `ST_LOAD` → `ST_IDLE` | `load_en` drops early | The load is aborted and nothing is committed. |
| `ST_READ` → `ST_IDLE` | The last bit has been shifted out | `done` is raised. |

Top module: `ofs_loader`

## Requirements
- R1: While reset is low and in the first cycle after it, every almost-empty output field equals `DEF_AE`, every almost-full output field equals `DEF_AF`, and `done` and `sdo_valid` are 0.
- R2: A stream is `8*FIELD_W` bits long. Stream bit j (counted from 0) lands in field j/`FIELD_W` at bit j%`FIELD_W`, so each field is sent LSB first. The fields appear in this order: queue 3 almost-empty, queue 3 almost-full, queue 2 almost-empty, queue 2 almost-full, and so on down to queue 0 almost-full. Queue q occupies bits [q*`FIELD_W` +: `FIELD_W`] of `ae_ofs` and of `af_ofs`.
- R3: A bit is taken on each rising edge at which `load_en` is high. The outputs keep their old values until the edge that takes the final bit. They show the new values from the cycle after that edge.
- R4: If `load_en` goes low before a full stream has been taken, the outputs stay unchanged and `done` stays 0. The next load starts again at stream bit 0.
- R5: `done` is high for exactly one cycle in two cases: in the cycle after the final bit of a complete load, and in the cycle after the last read-back bit.
- R6: When `cmd_valid` is high with `cmd_code` = 16'h0007 in an idle cycle with `load_en` low, `sdo_valid` rises in the next cycle. It stays high for `8*FIELD_W` cycles, and in those cycles `sdo` presents the stored image in the R2 stream order.
- R7: A command with any other `cmd_code` value is ignored: `sdo_valid` stays 0.
- R8: `load_en` and `load_bit` are ignored while a read-back runs, and the stored values stay unchanged. A read command that arrives during a load is ignored, and the load completes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock. |
| rst_n | input | 1 | Active-low synchronous reset. |
| load_en | input | 1 | Marks a valid serial stream bit in the current cycle. |
| load_bit | input | 1 | Serial stream data. |
| cmd_valid | input | 1 | Marks a command on `cmd_code`. |
| cmd_code | input | 16 | Command value; 16'h0007 requests read-back. |
| sdo | output | 1 | Serial read-back data. |
| sdo_valid | output | 1 | High while `sdo` carries read-back bits. |
| done | output | 1 | One-cycle pulse when a load or a read-back completes. |
| ae_ofs | output | 4*FIELD_W | Almost-empty offsets, queue q at [q*FIELD_W +: FIELD_W]. |
| af_ofs | output | 4*FIELD_W | Almost-full offsets, same packing. |

## Verification
A stream in which every field holds a distinct small value shows whether fields are mis-steered or mis-ordered. All-ones and all-zeros streams expose stuck or dropped bits. Random images, each loaded and then read back, test the bit order at every position. Truncated streams of random length, read commands with wrong codes, and load noise injected during a read-back separate a correct all-or-nothing commit from a design that leaks partial or ignored input into the stored values.

// File: rtl/ofs_pkg.sv
package ofs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_READ = 2'd2
    } ofs_state_e;

    // Stream slot of the almost-empty field of queue q (queues run high to low).
    function automatic int ae_slot(input int q, input int nq);
        return 2 * (nq - 1 - q);
    endfunction

    // Stream slot of the almost-full field of queue q.
    function automatic int af_slot(input int q, input int nq);
        return 2 * (nq - 1 - q) + 1;
    endfunction

endpackage

// File: rtl/ofs_ctrl.sv
module ofs_ctrl
    import ofs_pkg::*;
#(
    parameter int unsigned TOTAL  = 104,
    parameter int unsigned CMD_W  = 16,
    parameter logic [CMD_W-1:0] RD_CMD = 16'h0007
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en,
    input  logic             cmd_valid,
    input  logic [CMD_W-1:0] cmd_code,
    output ofs_state_e       state,
    output logic             shift_en,
    output logic             commit,
    output logic             rb_load,
    output logic             rb_shift,
    output logic             sdo_valid,
    output logic             done
);

    localparam int unsigned CNT_W = $clog2(TOTAL);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TOTAL - 1);

    ofs_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             done_q, done_d;
    logic             rd_req;

    assign rd_req = cmd_valid && (cmd_code == RD_CMD);

    // Next state and bit counter
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        done_d  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (load_en) begin
                    state_d = ST_LOAD;
                    cnt_d   = CNT_W'(1);
                end else if (rd_req) begin
                    state_d = ST_READ;
                    cnt_d   = '0;
                end
            end
            ST_LOAD: begin
                if (!load_en) begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end else if (cnt_q == LAST) begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                    done_d  = 1'b1;
                end else begin
                    cnt_d = cnt_q + CNT_W'(1);
                end
            end
            ST_READ: begin
                if (cnt_q == LAST) begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                    done_d  = 1'b1;
                end else begin
                    cnt_d = cnt_q + CNT_W'(1);
                end
            end
            default: begin
                state_d = ST_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            done_q  <= done_d;
        end
    end

    // Outputs
    always_comb begin
        shift_en  = 1'b0;
        commit    = 1'b0;
        rb_load   = 1'b0;
        rb_shift  = 1'b0;
        sdo_valid = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                shift_en = load_en;
                rb_load  = !load_en && rd_req;
            end
            ST_LOAD: begin
                shift_en = load_en;
                commit   = load_en && (cnt_q == LAST);
            end
            ST_READ: begin
                rb_shift  = 1'b1;
                sdo_valid = 1'b1;
            end
            default: ;
        endcase
    end

    assign state = state_q;
    assign done  = done_q;

endmodule

// File: rtl/ofs_shadow.sv
module ofs_shadow #(
    parameter int unsigned TOTAL = 104
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic             load_bit,
    output logic [TOTAL-1:0] img_next
);

    logic [TOTAL-1:0] shadow_q;

    // New bits enter at the top; after TOTAL shifts the first bit sits at bit 0.
    assign img_next = {load_bit, shadow_q[TOTAL-1:1]};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q <= '0;
        end else if (shift_en) begin
            shadow_q <= img_next;
        end
    end

endmodule

// File: rtl/ofs_bank.sv
module ofs_bank
    import ofs_pkg::*;
#(
    parameter int unsigned FIELD_W = 13,
    parameter int unsigned NUM_Q   = 4,
    parameter int unsigned DEF_AE  = 127,
    parameter int unsigned DEF_AF  = 255,
    localparam int unsigned TOTAL  = 2 * NUM_Q * FIELD_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     commit,
    input  logic [TOTAL-1:0]         img_in,
    output logic [TOTAL-1:0]         img,
    output logic [NUM_Q*FIELD_W-1:0] ae_ofs,
    output logic [NUM_Q*FIELD_W-1:0] af_ofs
);

    localparam logic [FIELD_W-1:0] AE_RST = FIELD_W'(DEF_AE);
    localparam logic [FIELD_W-1:0] AF_RST = FIELD_W'(DEF_AF);

    logic [TOTAL-1:0] img_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int q = 0; q < NUM_Q; q++) begin
                img_q[ae_slot(q, NUM_Q)*FIELD_W +: FIELD_W] <= AE_RST;
                img_q[af_slot(q, NUM_Q)*FIELD_W +: FIELD_W] <= AF_RST;
            end
        end else if (commit) begin
            img_q <= img_in;
        end
    end

    assign img = img_q;

    for (genvar q = 0; q < NUM_Q; q++) begin : g_queue
        localparam int unsigned AE_LO = ae_slot(q, NUM_Q) * FIELD_W;
        localparam int unsigned AF_LO = af_slot(q, NUM_Q) * FIELD_W;
        assign ae_ofs[q*FIELD_W +: FIELD_W] = img_q[AE_LO +: FIELD_W];
        assign af_ofs[q*FIELD_W +: FIELD_W] = img_q[AF_LO +: FIELD_W];
    end

endmodule

// File: rtl/ofs_readback.sv
module ofs_readback #(
    parameter int unsigned TOTAL = 104
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rb_load,
    input  logic             rb_shift,
    input  logic [TOTAL-1:0] img,
    output logic             sdo
);

    logic [TOTAL-1:0] sh_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else if (rb_load) begin
            sh_q <= img;
        end else if (rb_shift) begin
            sh_q <= {1'b0, sh_q[TOTAL-1:1]};
        end
    end

    assign sdo = sh_q[0];

endmodule

// File: rtl/ofs_loader.sv
module ofs_loader
    import ofs_pkg::*;
#(
    parameter int unsigned FIELD_W = 13,
    parameter int unsigned NUM_Q   = 4,
    parameter int unsigned CMD_W   = 16,
    parameter logic [CMD_W-1:0] RD_CMD = 16'h0007,
    parameter int unsigned DEF_AE  = 127,
    parameter int unsigned DEF_AF  = 255
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load_en,
    input  logic                     load_bit,
    input  logic                     cmd_valid,
    input  logic [CMD_W-1:0]         cmd_code,
    output logic                     sdo,
    output logic                     sdo_valid,
    output logic                     done,
    output logic [NUM_Q*FIELD_W-1:0] ae_ofs,
    output logic [NUM_Q*FIELD_W-1:0] af_ofs
);

    localparam int unsigned TOTAL = 2 * NUM_Q * FIELD_W;

    ofs_state_e       cur_state;
    logic             shift_en;
    logic             commit;
    logic             rb_load;
    logic             rb_shift;
    logic [TOTAL-1:0] img_next;
    logic [TOTAL-1:0] img;

    ofs_ctrl #(
        .TOTAL  (TOTAL),
        .CMD_W  (CMD_W),
        .RD_CMD (RD_CMD)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_en   (load_en),
        .cmd_valid (cmd_valid),
        .cmd_code  (cmd_code),
        .state     (cur_state),
        .shift_en  (shift_en),
        .commit    (commit),
        .rb_load   (rb_load),
        .rb_shift  (rb_shift),
        .sdo_valid (sdo_valid),
        .done      (done)
    );

    ofs_shadow #(
        .TOTAL (TOTAL)
    ) u_shadow (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_en),
        .load_bit (load_bit),
        .img_next (img_next)
    );

    ofs_bank #(
        .FIELD_W (FIELD_W),
        .NUM_Q   (NUM_Q),
        .DEF_AE  (DEF_AE),
        .DEF_AF  (DEF_AF)
    ) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .commit (commit),
        .img_in (img_next),
        .img    (img),
        .ae_ofs (ae_ofs),
        .af_ofs (af_ofs)
    );

    ofs_readback #(
        .TOTAL (TOTAL)
    ) u_rb (
        .clk      (clk),
        .rst_n    (rst_n),
        .rb_load  (rb_load),
        .rb_shift (rb_shift),
        .img      (img),
        .sdo      (sdo)
    );

endmodule

// File: rtl/ofs_loader_chk.sv
module ofs_loader_chk
    import ofs_pkg::*;
#(
    parameter int unsigned FIELD_W = 13,
    parameter int unsigned NUM_Q   = 4,
    parameter int unsigned CMD_W   = 16,
    parameter logic [CMD_W-1:0] RD_CMD = 16'h0007
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     load_en,
    input logic                     cmd_valid,
    input logic [CMD_W-1:0]         cmd_code,
    input logic                     sdo_valid,
    input logic                     done,
    input ofs_state_e               cur_state,
    input logic [NUM_Q*FIELD_W-1:0] ae_ofs,
    input logic [NUM_Q*FIELD_W-1:0] af_ofs
);

    // R5
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R3
    ofs_change_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((ae_ofs != $past(ae_ofs)) || (af_ofs != $past(af_ofs))) |-> done);

    // R6
    rd_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_state == ST_IDLE && !load_en && cmd_valid && cmd_code == RD_CMD)
        |=> sdo_valid);

    // R7
    bad_cmd_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_state == ST_IDLE && !load_en && cmd_valid && cmd_code != RD_CMD)
        |=> !sdo_valid);

    // R8
    read_keeps_ofs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sdo_valid |=> ($stable(ae_ofs) && $stable(af_ofs)));

endmodule

bind ofs_loader ofs_loader_chk #(
    .FIELD_W (FIELD_W),
    .NUM_Q   (NUM_Q),
    .CMD_W   (CMD_W),
    .RD_CMD  (RD_CMD)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_en   (load_en),
    .cmd_valid (cmd_valid),
    .cmd_code  (cmd_code),
    .sdo_valid (sdo_valid),
    .done      (done),
    .cur_state (cur_state),
    .ae_ofs    (ae_ofs),
    .af_ofs    (af_ofs)
);

// File: tb/ofs_loader_tb.sv
module ofs_loader_tb;

    localparam int W      = 13;
    localparam int NQ     = 4;
    localparam int T      = 2 * NQ * W;
    localparam int OW     = NQ * W;
    localparam int CLK_PERIOD = 10;
    localparam int DAE    = 200;
    localparam int DAF    = 300;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          load_en, load_bit, cmd_valid;
    logic [15:0]   cmd_code;
    logic          sdo, sdo_valid, done;
    logic [OW-1:0] ae_ofs, af_ofs;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    logic [T-1:0] exp_img;

    always #(CLK_PERIOD/2) clk = ~clk;

    ofs_loader #(
        .FIELD_W (W),
        .NUM_Q   (NQ),
        .CMD_W   (16),
        .RD_CMD  (16'h0007),
        .DEF_AE  (DAE),
        .DEF_AF  (DAF)
    ) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_en   (load_en),
        .load_bit  (load_bit),
        .cmd_valid (cmd_valid),
        .cmd_code  (cmd_code),
        .sdo       (sdo),
        .sdo_valid (sdo_valid),
        .done      (done),
        .ae_ofs    (ae_ofs),
        .af_ofs    (af_ofs)
    );

    // Expected parallel views of a stream image (R2 field order)
    function automatic logic [OW-1:0] exp_ae(input logic [T-1:0] img);
        logic [OW-1:0] r;
        for (int q = 0; q < NQ; q++) r[q*W +: W] = img[(2*(NQ-1-q))*W +: W];
        return r;
    endfunction

    function automatic logic [OW-1:0] exp_af(input logic [T-1:0] img);
        logic [OW-1:0] r;
        for (int q = 0; q < NQ; q++) r[q*W +: W] = img[(2*(NQ-1-q)+1)*W +: W];
        return r;
    endfunction

    function automatic logic [T-1:0] default_img();
        logic [T-1:0] r;
        for (int k = 0; k < 2*NQ; k++) r[k*W +: W] = (k % 2 == 0) ? W'(DAE) : W'(DAF);
        return r;
    endfunction

    function automatic logic [T-1:0] rand_img();
        logic [T-1:0] r;
        for (int i = 0; i < T; i++) r[i] = 1'($urandom % 2);
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [T-1:0] act, input logic [T-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic chk_ofs(input string req, input string what);
        chk(ae_ofs == exp_ae(exp_img), req, {what, " ae_ofs"}, T'(ae_ofs), T'(exp_ae(exp_img)));
        chk(af_ofs == exp_af(exp_img), req, {what, " af_ofs"}, T'(af_ofs), T'(exp_af(exp_img)));
    endtask

    // Drive nbits of img; nbits < T gives an aborted load. cmd_mid injects a read command.
    task automatic do_load(input logic [T-1:0] img, input int nbits, input bit cmd_mid);
        for (int i = 0; i < nbits; i++) begin
            @(negedge clk);
            if (i == T-1) chk_ofs("R3", "before final bit");
            if (cmd_mid && i == 31)
                chk(sdo_valid == 1'b0, "R8", "cmd during load", T'(sdo_valid), '0);
            cmd_valid = cmd_mid && (i == 30);
            cmd_code  = 16'h0007;
            load_en   = 1'b1;
            load_bit  = img[i];
        end
        @(negedge clk);
        load_en   = 1'b0;
        cmd_valid = 1'b0;
        if (nbits == T) begin
            exp_img = img;
            chk(done == 1'b1, "R5", "done after load", T'(done), T'(1));
            chk_ofs("R2", "after full load");
            @(negedge clk);
            chk(done == 1'b0, "R5", "done one cycle", T'(done), '0);
        end else begin
            chk(done == 1'b0, "R4", "no done on abort", T'(done), '0);
            chk_ofs("R4", "after aborted load");
        end
    endtask

    task automatic do_read(input bit noise);
        logic [T-1:0] got;
        bit allv;
        allv = 1'b1;
        @(negedge clk);
        load_en   = 1'b0;
        cmd_valid = 1'b1;
        cmd_code  = 16'h0007;
        @(negedge clk);
        cmd_valid = 1'b0;
        for (int i = 0; i < T; i++) begin
            got[i] = sdo;
            if (!sdo_valid) allv = 1'b0;
            if (noise) begin
                load_en  = 1'($urandom % 2);
                load_bit = 1'($urandom % 2);
            end
            @(negedge clk);
        end
        load_en = 1'b0;
        chk(allv, "R6", "sdo_valid held", T'(allv), T'(1));
        chk(got == exp_img, "R6", "readback stream", got, exp_img);
        chk(done == 1'b1, "R5", "done after readback", T'(done), T'(1));
        chk(sdo_valid == 1'b0, "R6", "sdo_valid ends", T'(sdo_valid), '0);
        chk_ofs("R8", "after readback");
    endtask

    task automatic bad_cmd(input logic [15:0] code);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_code  = code;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(sdo_valid == 1'b0, "R7", "wrong command code", T'(sdo_valid), '0);
        @(negedge clk);
        chk(sdo_valid == 1'b0 && done == 1'b0, "R7", "still idle", T'({sdo_valid, done}), '0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [T-1:0] img;
        void'($urandom(32'h5eed_0042));
        rst_n = 1'b0; load_en = 1'b0; load_bit = 1'b0;
        cmd_valid = 1'b0; cmd_code = '0;
        exp_img = default_img();
        repeat (3) @(negedge clk);
        chk_ofs("R1", "in reset");
        chk(done == 1'b0 && sdo_valid == 1'b0, "R1", "flags in reset", T'({done, sdo_valid}), '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk_ofs("R1", "after reset");
        chk(done == 1'b0 && sdo_valid == 1'b0, "R1", "flags after reset", T'({done, sdo_valid}), '0);

        // Distinct value per field exposes steering and order (R2)
        for (int k = 0; k < 2*NQ; k++) img[k*W +: W] = W'(k + 1);
        do_load(img, T, 1'b0);
        // Truncated load (R4), then a full load must restart from bit 0
        do_load(rand_img(), 50, 1'b0);
        do_load(rand_img(), T - 1, 1'b0);
        do_read(1'b0);
        bad_cmd(16'h0006);
        bad_cmd(16'h0107);
        // Read command in the middle of a load (R8)
        do_load(rand_img(), T, 1'b1);
        // Load noise during readback (R8)
        do_read(1'b1);
        do_load('1, T, 1'b0);
        do_read(1'b0);
        do_load('0, T, 1'b0);
        do_read(1'b0);

        for (int n = 0; n < 12; n++) begin
            if ($urandom % 3 == 0) do_load(rand_img(), 1 + int'($urandom % (T - 1)), 1'b0);
            do_load(rand_img(), T, 1'b0);
            do_read(1'($urandom % 2));
        end

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule